// File: doc/BRIEF.md
# Read Capture Tap Calibration Sequencer

This block runs once at start-up, before ordinary read traffic, to find a delay-line setting for each capture lane that places the sampling point well inside the window where read data is valid. Lane 0 is the strobe delay. Lane 1 is the data delay. Each lane has its own delay line, and the lanes are swept one after the other. For the active lane, the sequencer resets the delay line to zero taps. At each tap it gathers read-back words of a known training pattern. It then moves the line up by one tap, where one tap is about 75 ps. A setting is judged good only after an unbroken run of matching words.

The first good tap found is the opening edge of the window. The first bad tap after that is the closing edge. If both edges are found, the chosen tap is the midpoint of the good run. If the window is still open at the top tap, the chosen tap is the opening edge plus a fixed offset, clipped at the top tap. If no tap is ever good, an error flag is raised and calibration still completes. The chosen value is then driven into the delay line by a reset followed by that many increment pulses. This leaves each line at its result before the next lane starts or `done` rises.

Read-back words enter on a valid/ready stream. `smp_ready` is high only while the sequencer is measuring the current tap. A word is consumed on a cycle where `smp_valid` and `smp_ready` are both high. The source may hold or drop `smp_valid` at any time, and the sequencer may take as long as it needs. Words offered while `smp_ready` is low are not consumed. The source must present words taken at the delay setting currently applied to lane `cal_lane`.

Top module: `tapcal_top`

## Requirements
- R1: After reset, `done`, `err`, `smp_ready`, every `dly_rst`/`dly_inc` bit and every `tap_out` field are 0.
- R2: A `start` pulse while idle or done begins calibration with lane 0, then lane 1 in ascending order, with `cal_lane` naming the active lane. `done` drops the cycle after start. A `start` while calibration is running has no effect on the results.
- R3: `smp_ready` is high only while a tap is being measured, never in a cycle that pulses a delay line. The delay line of the active lane is reset once at the start of its sweep and then moved by one-tap increment pulses, never beyond the top tap 2**TAP_W-1.
- R4: A tap passes only after MATCH_N consecutive accepted words equal PATTERN (default 8'hA5, MATCH_N 4). Any accepted mismatch fails the tap, even after earlier matches.
- R5: When a passing run is followed by a failing tap, the result is floor((first pass + last pass)/2).
- R6: When the run is still passing at the top tap, the result is min(first pass + LEAD_OFS, top tap), with LEAD_OFS 10 by default.
- R7: When no tap of a lane passes, that lane's result is 0, `err` is set, and `done` still rises once all lanes are finished.
- R8: After choosing a result, the sequencer resets the lane's delay line and issues exactly that many increment pulses, so the line rests at `tap_out` for that lane.
- R9: `done`, `err` and `tap_out` hold their values from the rise of `done` until the next `start`.
- R10: Each lane keeps its own result, and delay pulses only ever go to lane `cal_lane`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calibration run |
| smp_valid | input | 1 | Read-back word offered |
| smp_data | input | DW | Read-back word |
| smp_ready | output | 1 | Sequencer accepts a word this cycle |
| cal_lane | output | LANE_W | Lane being calibrated (0 strobe, 1 data) |
| dly_rst | output | LANES | Per-lane delay line reset-to-zero pulse |
| dly_inc | output | LANES | Per-lane delay line one-tap increment pulse |
| tap_out | output | LANES x TAP_W | Chosen tap per lane |
| done | output | 1 | Calibration finished |
| err | output | 1 | At least one lane found no passing tap |

## Verification
The assertions check properties that must hold on every cycle. The stream never accepts a word while a delay line is being pulsed. At most one lane line receives a pulse at a time. Once `done` is high, it stays high and `err` and `tap_out` stay frozen until a new start. The bench scenarios show the rest. They show the results for a centred window, a window open at the top, saturation of the offset, an empty lane, and a tap that fails on its last word after three matches. They also show the final resting position of each line. The bench derives these from its own model of the delay lines, driven only by the pulse outputs.

// File: rtl/tapcal_pkg.sv
`timescale 1ns/1ps
package tapcal_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LRST,   // zero the active delay line before the sweep
    ST_MEAS,   // gather read-back words at the current tap
    ST_STEP,   // move one tap up
    ST_PICK,   // latch the chosen tap
    ST_PRST,   // zero the line before programming
    ST_PINC,   // walk the line up to the chosen tap
    ST_DONE
  } cal_st_e;
endpackage

// File: rtl/tapcal_match.sv
`timescale 1ns/1ps
module tapcal_match #(
  parameter int DW = 8,
  parameter logic [DW-1:0] PATTERN = 'hA5,
  parameter int MATCH_N = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          take,
  input  logic [DW-1:0] data,
  output logic          verdict_vld,
  output logic          verdict_pass
);
  localparam int CNT_W = $clog2(MATCH_N + 1);
  localparam logic [CNT_W-1:0] HIT_AT = CNT_W'(MATCH_N - 1);

  logic [CNT_W-1:0] run_q;
  logic             miss;
  logic             hit;

  assign miss         = (data != PATTERN);
  assign hit          = (run_q == HIT_AT);
  assign verdict_vld  = take && (miss || hit);
  assign verdict_pass = !miss;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           run_q <= '0;
    else if (clr)         run_q <= '0;
    else if (verdict_vld) run_q <= '0;
    else if (take)        run_q <= run_q + 1'b1;
  end
endmodule

// File: rtl/tapcal_window.sv
`timescale 1ns/1ps
module tapcal_window #(
  parameter int TAP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             upd,
  input  logic             pass,
  input  logic [TAP_W-1:0] tap,
  output logic             open_found,
  output logic [TAP_W-1:0] open_tap,
  output logic [TAP_W-1:0] last_tap
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_found <= 1'b0;
      open_tap   <= '0;
      last_tap   <= '0;
    end else if (clr) begin
      open_found <= 1'b0;
      open_tap   <= '0;
      last_tap   <= '0;
    end else if (upd && pass) begin
      if (!open_found) begin
        open_found <= 1'b1;
        open_tap   <= tap;
      end
      last_tap <= tap;
    end
  end
endmodule

// File: rtl/tapcal_pick.sv
`timescale 1ns/1ps
module tapcal_pick #(
  parameter int TAP_W    = 6,
  parameter int LEAD_OFS = 10
) (
  input  logic             open_found,
  input  logic             closed,
  input  logic [TAP_W-1:0] open_tap,
  input  logic [TAP_W-1:0] last_tap,
  output logic [TAP_W-1:0] pick,
  output logic             none
);
  localparam logic [TAP_W:0] TOP_W = {1'b0, {TAP_W{1'b1}}};
  localparam logic [TAP_W:0] OFS_W = (TAP_W+1)'(LEAD_OFS);

  logic [TAP_W:0] span_sum;
  logic [TAP_W:0] ofs_sum;

  assign span_sum = {1'b0, open_tap} + {1'b0, last_tap};
  assign ofs_sum  = {1'b0, open_tap} + OFS_W;
  assign none     = !open_found;

  always_comb begin
    if (!open_found)        pick = '0;
    else if (closed)        pick = span_sum[TAP_W:1];
    else if (ofs_sum > TOP_W) pick = TOP_W[TAP_W-1:0];
    else                    pick = ofs_sum[TAP_W-1:0];
  end
endmodule

// File: rtl/tapcal_top.sv
`timescale 1ns/1ps
module tapcal_top
  import tapcal_pkg::*;
#(
  parameter int LANES    = 2,
  parameter int TAP_W    = 6,
  parameter int DW       = 8,
  parameter logic [DW-1:0] PATTERN = 'hA5,
  parameter int MATCH_N  = 4,
  parameter int LEAD_OFS = 10,
  localparam int LANE_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic                        smp_valid,
  input  logic [DW-1:0]               smp_data,
  output logic                        smp_ready,
  output logic [LANE_W-1:0]           cal_lane,
  output logic [LANES-1:0]            dly_rst,
  output logic [LANES-1:0]            dly_inc,
  output logic [LANES-1:0][TAP_W-1:0] tap_out,
  output logic                        done,
  output logic                        err
);
  localparam logic [TAP_W-1:0]  TAP_TOP   = {TAP_W{1'b1}};
  localparam logic [LANE_W-1:0] LANE_LAST = LANE_W'(LANES - 1);

  cal_st_e                     st_q;
  logic [LANE_W-1:0]           lane_q;
  logic [TAP_W-1:0]            tap_q;
  logic [TAP_W-1:0]            prog_q;
  logic                        closed_q;
  logic                        err_q;
  logic [LANES-1:0][TAP_W-1:0] res_q;

  logic             take;
  logic             v_vld, v_pass;
  logic             open_found;
  logic [TAP_W-1:0] open_tap, last_tap;
  logic [TAP_W-1:0] pick_w;
  logic             none_w;
  logic             last_lane;
  logic             at_top;
  cal_st_e          adv_st;

  assign smp_ready = (st_q == ST_MEAS);
  assign take      = smp_valid && smp_ready;
  assign last_lane = (lane_q == LANE_LAST);
  assign at_top    = (tap_q == TAP_TOP);
  assign adv_st    = last_lane ? ST_DONE : ST_LRST;

  tapcal_match #(.DW(DW), .PATTERN(PATTERN), .MATCH_N(MATCH_N)) u_match (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (st_q == ST_LRST || st_q == ST_STEP),
    .take        (take),
    .data        (smp_data),
    .verdict_vld (v_vld),
    .verdict_pass(v_pass)
  );

  tapcal_window #(.TAP_W(TAP_W)) u_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (st_q == ST_LRST),
    .upd       (v_vld),
    .pass      (v_pass),
    .tap       (tap_q),
    .open_found(open_found),
    .open_tap  (open_tap),
    .last_tap  (last_tap)
  );

  tapcal_pick #(.TAP_W(TAP_W), .LEAD_OFS(LEAD_OFS)) u_pick (
    .open_found(open_found),
    .closed    (closed_q),
    .open_tap  (open_tap),
    .last_tap  (last_tap),
    .pick      (pick_w),
    .none      (none_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      lane_q   <= '0;
      tap_q    <= '0;
      prog_q   <= '0;
      closed_q <= 1'b0;
      err_q    <= 1'b0;
      res_q    <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            lane_q <= '0;
            err_q  <= 1'b0;
            res_q  <= '0;
            st_q   <= ST_LRST;
          end
        end
        ST_LRST: begin
          tap_q    <= '0;
          closed_q <= 1'b0;
          st_q     <= ST_MEAS;
        end
        ST_MEAS: begin
          if (v_vld) begin
            if (v_pass) begin
              st_q <= at_top ? ST_PICK : ST_STEP;
            end else if (open_found) begin
              closed_q <= 1'b1;
              st_q     <= ST_PICK;
            end else begin
              st_q <= at_top ? ST_PICK : ST_STEP;
            end
          end
        end
        ST_STEP: begin
          tap_q <= tap_q + 1'b1;
          st_q  <= ST_MEAS;
        end
        ST_PICK: begin
          res_q[lane_q] <= pick_w;
          prog_q        <= pick_w;
          if (none_w) err_q <= 1'b1;
          st_q <= ST_PRST;
        end
        ST_PRST: begin
          if (prog_q == '0) begin
            st_q   <= adv_st;
            lane_q <= last_lane ? lane_q : lane_q + 1'b1;
          end else begin
            st_q <= ST_PINC;
          end
        end
        ST_PINC: begin
          prog_q <= prog_q - 1'b1;
          if (prog_q == TAP_W'(1)) begin
            st_q   <= adv_st;
            lane_q <= last_lane ? lane_q : lane_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic sel;
    assign sel        = (lane_q == LANE_W'(g));
    assign dly_rst[g] = sel && (st_q == ST_LRST || st_q == ST_PRST);
    assign dly_inc[g] = sel && (st_q == ST_STEP || st_q == ST_PINC);
  end

  assign cal_lane = lane_q;
  assign tap_out  = res_q;
  assign done     = (st_q == ST_DONE);
  assign err      = err_q;
endmodule

// File: rtl/tapcal_chk.sv
`timescale 1ns/1ps
module tapcal_chk #(
  parameter int LANES = 2,
  parameter int TAP_W = 6
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        start,
  input logic                        smp_ready,
  input logic [LANES-1:0]            dly_rst,
  input logic [LANES-1:0]            dly_inc,
  input logic [LANES-1:0][TAP_W-1:0] tap_out,
  input logic                        done,
  input logic                        err
);
  // R3
  ready_vs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready |-> (dly_inc == '0) && (dly_rst == '0));

  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dly_inc, dly_rst}));

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);

  // R9
  tap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> $stable(tap_out));

  // R9
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> $stable(err));

  // R3
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !smp_ready && (dly_inc == '0));
endmodule

bind tapcal_top tapcal_chk #(.LANES(LANES), .TAP_W(TAP_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .smp_ready(smp_ready),
  .dly_rst  (dly_rst),
  .dly_inc  (dly_inc),
  .tap_out  (tap_out),
  .done     (done),
  .err      (err)
);

// File: tb/tb_tapcal_top.sv
`timescale 1ns/1ps
module tb_tapcal_top;
  localparam int LANES = 2;
  localparam int TAP_W = 6;
  localparam int DW    = 8;
  localparam logic [DW-1:0] PAT = 8'hA5;
  localparam int TOP   = 63;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic smp_valid = 1'b0;
  logic [DW-1:0] smp_data = '0;
  logic smp_ready;
  logic [0:0] cal_lane;
  logic [LANES-1:0] dly_rst, dly_inc;
  logic [LANES-1:0][TAP_W-1:0] tap_out;
  logic done, err;

  always #2 clk = ~clk;

  tapcal_top dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .smp_valid(smp_valid), .smp_data(smp_data), .smp_ready(smp_ready),
    .cal_lane(cal_lane), .dly_rst(dly_rst), .dly_inc(dly_inc),
    .tap_out(tap_out), .done(done), .err(err)
  );

  int checks = 0;
  int errors = 0;
  int wlo[LANES];
  int whi[LANES];
  int wflaky[LANES];
  int mtap[LANES];
  int kcnt = 0;
  bit src_on = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // Delay-line model and read-back source, evaluated between clock edges.
  initial begin
    for (int l = 0; l < LANES; l++) mtap[l] = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (smp_valid && smp_ready) kcnt++;
        if (dly_inc != '0 || dly_rst != '0) begin
          // R3 and R10: pulses only on the active lane, line stays within range
          chk("R10 pulse lane", (dly_inc | dly_rst) == (LANES'(1) << cal_lane), 1);
          chk("R3 pulse while ready", smp_ready, 0);
        end
        for (int l = 0; l < LANES; l++) begin
          if (dly_rst[l]) begin mtap[l] = 0; kcnt = 0; end
          if (dly_inc[l]) begin mtap[l]++; kcnt = 0; end
        end
        if (dly_inc != '0) chk("R3 tap range", mtap[int'(cal_lane)] <= TOP, 1);
        begin
          int ln, t;
          bit good;
          ln = int'(cal_lane);
          t  = mtap[ln];
          good = (t >= wlo[ln]) && (t <= whi[ln]) && !(t == wflaky[ln] && kcnt >= 3);
          smp_data  = good ? PAT : (PAT ^ 8'h10);
          smp_valid = src_on && (($urandom % 4) != 0);
        end
      end
    end
  end

  task automatic run(input int lo0, input int hi0, input int lo1, input int hi1,
                     input int fl1, input int e0, input int e1, input int eerr,
                     input bit mid_start, input string tag);
    int cyc;
    logic [LANES-1:0][TAP_W-1:0] snap;
    wlo[0] = lo0; whi[0] = hi0; wflaky[0] = -1;
    wlo[1] = lo1; whi[1] = hi1; wflaky[1] = fl1;
    src_on = 1'b1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk({"R2 done drops after start ", tag}, done, 0);
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (mid_start && cyc == 150) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
    if (!done) begin
      chk({"R2 completion ", tag}, 0, 1);
      return;
    end
    // R5/R6/R7/R10 results per lane
    chk({"R10 lane0 result ", tag}, int'(tap_out[0]), e0);
    chk({"R10 lane1 result ", tag}, int'(tap_out[1]), e1);
    chk({"R7 err ", tag}, err, eerr);
    // R8 lines rest at the chosen taps
    chk({"R8 lane0 line ", tag}, mtap[0], e0);
    chk({"R8 lane1 line ", tag}, mtap[1], e1);
    snap = tap_out;
    repeat (5) @(negedge clk);
    chk({"R9 done held ", tag}, done, 1);
    chk({"R9 taps held ", tag}, int'(tap_out == snap), 1);
    src_on = 1'b0;
  endtask

  initial begin
    for (int l = 0; l < LANES; l++) begin wlo[l] = -1; whi[l] = -1; wflaky[l] = -1; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 done", done, 0);
    chk("R1 err", err, 0);
    chk("R1 ready", smp_ready, 0);
    chk("R1 pulses", int'({dly_inc, dly_rst}), 0);
    chk("R1 taps", int'(tap_out), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R5: both edges on both lanes
    run(10, 30, 5, 20, -1, 20, 12, 0, 1'b0, "centred");
    // R6: open at top, offset and saturation; R2 start while busy ignored
    run(50, 63, 58, 63, -1, 60, 63, 0, 1'b1, "open-top");
    // R7: empty lane 0, narrow window lane 1
    run(-1, -1, 0, 3, -1, 0, 1, 1, 1'b0, "empty");
    // R4: tap 30 of lane 1 matches 3 times then fails, closing the window
    run(20, 40, 1, 62, 30, 30, 15, 0, 1'b0, "flaky");

    summary();
    $finish;
  end

  initial begin
    #600000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end
endmodule